// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Pin Interrupt Styles

This block gives software control over sixteen general-purpose pins through a small word-addressed register bus. Each pin can be turned into an output that drives a programmed level, or into an input whose level can be read back. Pin levels pass through a two-stage synchroniser before they are used anywhere inside the block.

Every pin also has its own interrupt style, chosen from a 3-bit field. The style can be an active-high level, an active-low level, a rising edge, a falling edge or any transition. When a pin's condition is seen, its status bit is set and stays set until software clears it by writing a one to that bit. A level-style status bit is set again on every cycle in which its condition still holds, so clearing it only succeeds once the pin has left that level. Each status bit drives its own interrupt line.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every line is an input (pad_oe all 0), the direction register reads 0xFFFF, and the output register, both style registers, the status register and irq all read 0.
- R2: The direction register is at address 0. Bit i set to 1 makes line i an input and turns its driver off (pad_oe[i]=0). Bit i set to 0 makes it an output (pad_oe[i]=1). The register reads back as written.
- R3: The output register is at address 1. pad_out follows it one cycle after the write, and it reads back as written.
- R4: The input register is at address 2. It returns the pad levels after two synchroniser flops, so a change on pad_in shows in the read data after two rising clock edges. Writes to address 2 are ignored.
- R5: The style register at address 3 holds lines 0 to 7 and the one at address 4 holds lines 8 to 15. Line i uses bits [3*(i mod 8)+2 : 3*(i mod 8)], and both registers use bits [23:0].
- R6: Style code 0 (active high) sets status bit i while the synchronised pin is 1. Code 1 (active low) sets it while the pin is 0.
- R7: Style code 2 sets status on a 0-to-1 change of the synchronised pin, code 3 on a 1-to-0 change, and code 4 on either change.
- R8: Style codes 5, 6 and 7 never set a status bit.
- R9: The status register is at address 5. Writing 1 to bit i clears it and writing 0 leaves it unchanged. A set bit otherwise stays set, and irq[i] equals status bit i.
- R10: A level-style status bit that is cleared while its condition still holds reads as set again right after the clear.
- R11: A pad change that meets the line's style shows on irq on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for reg_addr (combinational) |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Drive value per line |
| pad_oe | output | 16 | Driver enable per line, 1 drives |
| irq | output | 16 | Per-line interrupt, equal to the status bit |

## Verification
A wrong style decode or a wrong edge reference shows up as an irq bit that is set or missing on the third edge after a pad change. The bench samples at exactly that cycle and one cycle earlier, so a synchroniser that is too short or too long is caught. A broken clear path shows up on the first status read after the write, either as a level bit that stays cleared or as an edge bit that does not clear. Direction and output errors show on pad_oe and pad_out one cycle after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int SYNC_STAGES = 2;

    localparam logic [2:0] ADDR_DIR  = 3'd0;
    localparam logic [2:0] ADDR_OUT  = 3'd1;
    localparam logic [2:0] ADDR_IN   = 3'd2;
    localparam logic [2:0] ADDR_STYL = 3'd3;
    localparam logic [2:0] ADDR_STYH = 3'd4;
    localparam logic [2:0] ADDR_STAT = 3'd5;

    localparam logic [2:0] STY_HIGH = 3'd0;
    localparam logic [2:0] STY_LOW  = 3'd1;
    localparam logic [2:0] STY_RISE = 3'd2;
    localparam logic [2:0] STY_FALL = 3'd3;
    localparam logic [2:0] STY_BOTH = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q[s] <= '0;
                else if (s == 0)
                    chain_q[s] <= d_in;
                else
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_bank_pkg::*;
#(
    parameter int STY_W = 3
) (
    input  logic             cur,
    input  logic             prev,
    input  logic [STY_W-1:0] style,
    output logic             hit
);
    always_comb begin
        case (style)
            STY_HIGH: hit = cur;
            STY_LOW:  hit = ~cur;
            STY_RISE: hit = cur & ~prev;
            STY_FALL: hit = ~cur & prev;
            STY_BOTH: hit = cur ^ prev;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int STY_W  = 3,
    parameter int ADDR_W = 3,
    parameter int DATA_W = (NLINES / 2) * STY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] irq
);
    localparam int GROUP = NLINES / 2;

    typedef struct packed {
        logic [NLINES-1:0]             dir;
        logic [NLINES-1:0]             out;
        logic [NLINES-1:0]             stat;
        logic [NLINES-1:0]             prev;
        logic [GROUP-1:0][STY_W-1:0]   sty_lo;
        logic [GROUP-1:0][STY_W-1:0]   sty_hi;
    } bank_regs_t;

    bank_regs_t        regs_d, regs_q;
    logic [NLINES-1:0] pin_s;
    logic [NLINES-1:0] hit;
    logic [NLINES-1:0] clr_mask;

    gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pin_s)
    );

    genvar i;
    generate
        for (i = 0; i < NLINES; i++) begin : g_line
            logic [STY_W-1:0] line_style;
            if (i < GROUP) begin : g_lo
                assign line_style = regs_q.sty_lo[i % GROUP];
            end else begin : g_hi
                assign line_style = regs_q.sty_hi[i % GROUP];
            end
            gpio_line_detect #(.STY_W(STY_W)) u_det (
                .cur   (pin_s[i]),
                .prev  (regs_q.prev[i]),
                .style (line_style),
                .hit   (hit[i])
            );
        end
    endgenerate

    always_comb begin
        regs_d      = regs_q;
        clr_mask    = '0;
        regs_d.prev = pin_s;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_DIR:  regs_d.dir    = reg_wdata[NLINES-1:0];
                ADDR_OUT:  regs_d.out    = reg_wdata[NLINES-1:0];
                ADDR_STYL: regs_d.sty_lo = reg_wdata;
                ADDR_STYH: regs_d.sty_hi = reg_wdata;
                ADDR_STAT: clr_mask      = reg_wdata[NLINES-1:0];
                default:   ;
            endcase
        end
        regs_d.stat = (regs_q.stat & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.dir <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DIR:  reg_rdata = DATA_W'(regs_q.dir);
            ADDR_OUT:  reg_rdata = DATA_W'(regs_q.out);
            ADDR_IN:   reg_rdata = DATA_W'(pin_s);
            ADDR_STYL: reg_rdata = regs_q.sty_lo;
            ADDR_STYH: reg_rdata = regs_q.sty_hi;
            ADDR_STAT: reg_rdata = DATA_W'(regs_q.stat);
            default:   reg_rdata = '0;
        endcase
    end

    assign pad_oe  = ~regs_q.dir;
    assign pad_out = regs_q.out;
    assign irq     = regs_q.stat;
endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NLINES-1:0] pad_in,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic [NLINES-1:0] irq
);
    logic [1:0]        age_q;
    logic [NLINES-1:0] clr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    assign clr_seen = (reg_wr && reg_addr == ADDR_STAT) ? reg_wdata[NLINES-1:0] : '0;

    // R1: first edge after reset sees the reset values
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (irq == '0 && pad_oe == '0 && pad_out == '0));

    // R2: direction write reaches the driver enables
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DIR) |=> (pad_oe == ~$past(reg_wdata[NLINES-1:0])));

    // R3: output write reaches the pads
    a_r3_out_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_OUT) |=> (pad_out == $past(reg_wdata[NLINES-1:0])));

    // R4: input read equals the pad level two edges back
    a_r4_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && reg_addr == ADDR_IN) |-> (reg_rdata[NLINES-1:0] == $past(pad_in, 2)));

    // R9: a set bit not written with 1 stays set
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~clr_seen) != '0) |=> ((irq & $past(irq & ~clr_seen)) == $past(irq & ~clr_seen)));
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(
    .NLINES (NLINES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/gpio_pin_bank_test.sv
module gpio_pin_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int K_RD = 0;
    localparam int K_IRQ = 1;
    localparam int K_OE = 2;
    localparam int K_OUT = 3;

    typedef struct {
        int          kind;
        logic [23:0] exp;
        string       tag;
    } exp_item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [23:0] reg_wdata = 0;
    logic [23:0] reg_rdata;
    logic [15:0] pad_in = 0;
    logic [15:0] pad_out, pad_oe, irq;

    int        n_run = 0;
    int        n_fail = 0;
    bit        done = 0;
    exp_item_t sb_q[$];
    event      sample_ev;

    gpio_pin_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            exp_item_t it;
            logic [23:0] act;
            @(sample_ev);
            #1;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = reg_rdata;
                K_IRQ:   act = {8'h0, irq};
                K_OE:    act = {8'h0, pad_oe};
                default: act = {8'h0, pad_out};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [2:0] addr, input logic [23:0] exp, input string tag);
        exp_item_t it;
        reg_addr = addr;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic wr(input logic [2:0] addr, input logic [23:0] data);
        @(negedge clk);
        reg_wr = 1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] styles(input logic [2:0] f0, input logic [2:0] f1,
                                            input logic [2:0] f2, input logic [2:0] f3,
                                            input logic [2:0] f4, input logic [2:0] f5,
                                            input logic [2:0] f6, input logic [2:0] f7);
        return {f7, f6, f5, f4, f3, f2, f1, f0};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk(K_RD, 3'd0, 24'h00FFFF, "R1 dir");
        chk(K_RD, 3'd1, 24'h0, "R1 out");
        chk(K_RD, 3'd3, 24'h0, "R1 style lo");
        chk(K_RD, 3'd4, 24'h0, "R1 style hi");
        chk(K_RD, 3'd5, 24'h0, "R1 status");
        chk(K_OE, 3'd5, 24'h0, "R1 pad_oe");
        chk(K_IRQ, 3'd5, 24'h0, "R1 irq");

        // park all styles at no-detect code
        wr(3'd3, 24'hFFFFFF);
        wr(3'd4, 24'hFFFFFF);

        // R2 / R3
        wr(3'd0, 24'h0000F0);
        chk(K_OE, 3'd0, 24'h00FF0F, "R2 pad_oe");
        chk(K_RD, 3'd0, 24'h0000F0, "R2 readback");
        wr(3'd1, 24'h00A5A5);
        chk(K_OUT, 3'd1, 24'h00A5A5, "R3 pad_out");
        chk(K_RD, 3'd1, 24'h00A5A5, "R3 readback");

        // R4 input path and read-only
        @(negedge clk); pad_in = 16'h1234;
        idle(1);
        chk(K_RD, 3'd2, 24'h0, "R4 not yet after one edge");
        idle(1);
        chk(K_RD, 3'd2, 24'h001234, "R4 input after two edges");
        wr(3'd2, 24'h00FFFF);
        chk(K_RD, 3'd2, 24'h001234, "R4 write ignored");

        // R8 codes 7 never flag
        @(negedge clk); pad_in = 16'h0000;
        idle(4);
        chk(K_RD, 3'd5, 24'h0, "R8 no-detect code");

        // R5 configure styles
        wr(3'd3, styles(3'd2, 3'd3, 3'd4, 3'd0, 3'd1, 3'd5, 3'd6, 3'd7));
        wr(3'd4, styles(3'd7, 3'd2, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7));
        chk(K_RD, 3'd3, styles(3'd2, 3'd3, 3'd4, 3'd0, 3'd1, 3'd5, 3'd6, 3'd7), "R5 style lo readback");
        chk(K_RD, 3'd4, 24'hFFFFD7, "R5 style hi field at line 9");
        idle(1);
        // R6 active low with pad 0
        chk(K_RD, 3'd5, 24'h000010, "R6 active low sets");
        chk(K_IRQ, 3'd5, 24'h000010, "R9 irq mirrors status");
        // R10 clear while low persists
        wr(3'd5, 24'h000010);
        chk(K_RD, 3'd5, 24'h000010, "R10 level re-asserts");

        // R7 / R6 rising lines
        @(negedge clk); pad_in = 16'h021F;
        idle(3);
        chk(K_IRQ, 3'd5, 24'h00021D, "R7 rise/both, R6 high");
        wr(3'd5, 24'h000000);
        chk(K_RD, 3'd5, 24'h00021D, "R9 write zero no effect");
        wr(3'd5, 24'h000215);
        chk(K_RD, 3'd5, 24'h000008, "R9 W1C clears selected");
        wr(3'd5, 24'h000008);
        chk(K_RD, 3'd5, 24'h000008, "R10 high level re-asserts");

        // falling edges
        @(negedge clk); pad_in = 16'h0000;
        idle(3);
        chk(K_IRQ, 3'd5, 24'h00001E, "R7 fall/both, R6 low");
        wr(3'd5, 24'h00FFFF);
        chk(K_RD, 3'd5, 24'h000010, "R10 only held level survives");

        // R11 latency
        @(negedge clk); pad_in = 16'h0001;
        idle(2);
        chk(K_IRQ, 3'd5, 24'h000010, "R11 not before third edge");
        idle(1);
        chk(K_IRQ, 3'd5, 24'h000011, "R11 on third edge");

        idle(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule